// File: doc/BRIEF.md
# Banked Register Window Decoder

This block is a word-addressed register slave that reaches several internal register banks through one shared 16-word address window. Software first writes a bank code into a select register at word index 0. Later accesses to word indices 0x10 through 0x1F then land in the bank that code names. There are three banks. The status bank gives a read-only view of words driven by the surrounding hardware. The configuration bank holds read/write words whose stored values also drive output ports. The statistics bank holds a 64-bit count of packet-sent events, which software reads as two 32-bit halves.

The two halves are read one at a time, so the counter could advance between the two reads. To keep the pair consistent, a read of the low half copies the high half into a shadow register. A small two-state machine tracks whether that shadow is pending. In `SPLIT_IDLE` no shadow is pending, and a high-half read returns the live upper word. A low-half read always moves the machine to `SPLIT_ARMED`, capturing the upper word at the same instant. In `SPLIT_ARMED`, a high-half read returns the shadow and moves the machine back to `SPLIT_IDLE`. Read data is registered: it appears on `rd_data` together with `rd_valid` one clock after the request.

Top module: `bank_window_top`

## Requirements
- R1: After reset the bank code is 0, all configuration words are 0, the packet counter holds the parameter `CNT_RESET`, `rd_valid` is 0 and `rd_data` is 0.
- R2: A write to word index 0 stores `wr_data[1:0]` as the bank code. A read of index 0 returns that code in bits [1:0] with zeros above it.
- R3: A window access in the cycle right after a bank code write already reaches the newly selected bank.
- R4: Bank code 0 (status) returns `status_in[32*k +: 32]` at window offset k for k < `NUM_STATUS`, and zero at higher offsets. Writes to this bank change nothing.
- R5: Bank code 1 (configuration) stores window writes at offsets below `NUM_CFG`. Offset k reads back and drives `cfg_out[32*k +: 32]`. Higher offsets read zero and discard writes.
- R6: Bank code 2 (statistics) returns the low 32 counter bits at offset 0 and the high 32 bits at offset 1. Other offsets read zero, and window writes never change the counter.
- R7: Reading offset 0 of bank 2 captures the high half and enters `SPLIT_ARMED`. The next offset 1 read returns the captured value and goes to `SPLIT_IDLE`. An offset 1 read in `SPLIT_IDLE` returns the live high half.
- R8: The counter adds one for each cycle with `pkt_sent` high and wraps from 2^64-1 to 0. A read in the same cycle as a pulse returns the value from before the increment.
- R9: Bank code 3 is unimplemented: window reads return zero and window writes are discarded.
- R10: `rd_valid` rises exactly one cycle after each read request. Indices other than 0 and 0x10 to 0x1F read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Bus access request for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word index |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| pkt_sent | input | 1 | Packet-sent event, one count per high cycle |
| status_in | input | 32*NUM_STATUS | Status words shown in bank 0 |
| cfg_out | output | 32*NUM_CFG | Stored configuration words |

## Verification
The case to watch is a packet-sent pulse arriving in the same cycle as a low-half read of the statistics bank. The counter is reset to eight below its wrap point and pulsed until the eighth pulse coincides with the low read. The bench then expects the low half to show the value before the increment. It also expects the following high read to return the pre-wrap upper word from the shadow, while a second high read shows the live, wrapped upper word of zero. The other pairing that can share a cycle is a bank select write followed at once by a window access. It is judged by sweeping every bank code over every window offset right after each select write.

// File: rtl/bank_window_pkg.sv
package bank_window_pkg;
    typedef enum logic [1:0] {
        BANK_STATUS = 2'd0,
        BANK_CONFIG = 2'd1,
        BANK_STATS  = 2'd2,
        BANK_NONE   = 2'd3
    } bank_e;

    typedef enum logic {
        SPLIT_IDLE  = 1'b0,
        SPLIT_ARMED = 1'b1
    } split_e;

    localparam int WORD_W = 32;
endpackage

// File: rtl/bank_sel_reg.sv
module bank_sel_reg
    import bank_window_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_code,
    output bank_e      bank_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= BANK_STATUS;
        else if (wr_en)
            bank_q <= bank_e'(wr_code);
    end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
    import bank_window_pkg::*;
#(
    parameter int NUM_CFG = 4,
    parameter int OFF_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [OFF_W-1:0]          off,
    input  logic [WORD_W-1:0]         wr_data,
    output logic [WORD_W-1:0]         rd_word,
    output logic [NUM_CFG*WORD_W-1:0] cfg_flat
);
    logic [WORD_W-1:0] words [NUM_CFG];

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[g] <= '0;
            else if (wr_en && off == OFF_W'(g))
                words[g] <= wr_data;
        end
        assign cfg_flat[g*WORD_W +: WORD_W] = words[g];
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_CFG; i++)
            if (off == OFF_W'(i))
                rd_word = words[i];
    end
endmodule

// File: rtl/pkt_counter.sv
module pkt_counter
    import bank_window_pkg::*;
#(
    parameter logic [63:0] CNT_RESET = 64'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic [WORD_W-1:0] lo_word,
    output logic [WORD_W-1:0] hi_word,
    output logic [63:0]       count
);
    split_e            state_q, state_d;
    logic [WORD_W-1:0] shadow_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= CNT_RESET;
        else if (pkt)
            count <= count + 64'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (rd_lo)
            shadow_q <= count[63:32];
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SPLIT_IDLE:  if (rd_lo) state_d = SPLIT_ARMED;
            SPLIT_ARMED: if (rd_lo) state_d = SPLIT_ARMED;
                         else if (rd_hi) state_d = SPLIT_IDLE;
            default:     state_d = SPLIT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SPLIT_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        lo_word = count[31:0];
        unique case (state_q)
            SPLIT_IDLE:  hi_word = count[63:32];
            SPLIT_ARMED: hi_word = shadow_q;
            default:     hi_word = count[63:32];
        endcase
    end
endmodule

// File: rtl/bank_window_top.sv
module bank_window_top
    import bank_window_pkg::*;
#(
    parameter int          ADDR_W     = 6,
    parameter int          SEL_IDX    = 0,
    parameter int          WIN_BASE   = 16,
    parameter int          WIN_WORDS  = 16,
    parameter int          NUM_STATUS = 2,
    parameter int          NUM_CFG    = 4,
    parameter logic [63:0] CNT_RESET  = 64'd0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [31:0]                  wr_data,
    output logic [31:0]                  rd_data,
    output logic                         rd_valid,
    input  logic                         pkt_sent,
    input  logic [32*NUM_STATUS-1:0]     status_in,
    output logic [32*NUM_CFG-1:0]        cfg_out
);
    localparam int                OFF_W  = $clog2(WIN_WORDS);
    localparam logic [ADDR_W-1:0] SEL_A  = ADDR_W'(SEL_IDX);
    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(WIN_BASE + WIN_WORDS - 1);

    bank_e             bank_q;
    logic              sel_hit, win_hit;
    logic [OFF_W-1:0]  off;
    logic              cfg_wr, stat_rd_lo, stat_rd_hi;
    logic [31:0]       cfg_word, cnt_lo, cnt_hi, stat_word, rd_next;
    logic [63:0]       pkt_count;

    assign sel_hit = req && (addr == SEL_A);
    assign win_hit = req && (addr >= WIN_LO) && (addr <= WIN_HI);
    assign off     = OFF_W'(addr - WIN_LO);

    assign cfg_wr     = win_hit && we && (bank_q == BANK_CONFIG);
    assign stat_rd_lo = win_hit && !we && (bank_q == BANK_STATS) && (off == OFF_W'(0));
    assign stat_rd_hi = win_hit && !we && (bank_q == BANK_STATS) && (off == OFF_W'(1));

    bank_sel_reg u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sel_hit && we),
        .wr_code (wr_data[1:0]),
        .bank_q  (bank_q)
    );

    cfg_bank #(.NUM_CFG(NUM_CFG), .OFF_W(OFF_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .off      (off),
        .wr_data  (wr_data),
        .rd_word  (cfg_word),
        .cfg_flat (cfg_out)
    );

    pkt_counter #(.CNT_RESET(CNT_RESET)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pkt     (pkt_sent),
        .rd_lo   (stat_rd_lo),
        .rd_hi   (stat_rd_hi),
        .lo_word (cnt_lo),
        .hi_word (cnt_hi),
        .count   (pkt_count)
    );

    always_comb begin
        stat_word = '0;
        if (off == OFF_W'(0))      stat_word = cnt_lo;
        else if (off == OFF_W'(1)) stat_word = cnt_hi;
    end

    logic [31:0] status_word;
    always_comb begin
        status_word = '0;
        for (int i = 0; i < NUM_STATUS; i++)
            if (off == OFF_W'(i))
                status_word = status_in[i*32 +: 32];
    end

    always_comb begin
        rd_next = '0;
        if (sel_hit) begin
            rd_next = {30'd0, bank_q};
        end else if (win_hit) begin
            unique case (bank_q)
                BANK_STATUS: rd_next = status_word;
                BANK_CONFIG: rd_next = cfg_word;
                BANK_STATS:  rd_next = stat_word;
                BANK_NONE:   rd_next = '0;
                default:     rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= req && !we;
            if (req && !we)
                rd_data <= rd_next;
        end
    end
endmodule

// File: rtl/bank_window_chk.sv
module bank_window_chk
    import bank_window_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int WIN_BASE  = 16,
    parameter int WIN_WORDS = 16,
    parameter int NUM_CFG   = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req,
    input logic                  we,
    input logic [ADDR_W-1:0]     addr,
    input logic [31:0]           rd_data,
    input logic                  rd_valid,
    input logic                  pkt_sent,
    input bank_e                 bank_q,
    input logic [63:0]           pkt_count,
    input logic [32*NUM_CFG-1:0] cfg_out
);
    logic in_win;
    assign in_win = (int'(addr) >= WIN_BASE) && (int'(addr) < WIN_BASE + WIN_WORDS);

    // R10
    rd_valid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we) |=> rd_valid);

    // R10
    rd_valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && !we) |=> !rd_valid);

    // R9
    none_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && in_win && bank_q == BANK_NONE) |=> (rd_data == 32'd0));

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_sent |=> (pkt_count == $past(pkt_count) + 64'd1));

    // R8
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_sent |=> $stable(pkt_count));

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && we) |=> $stable(cfg_out));

    // R2
    sel_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && addr == '0) |=> (rd_data[31:2] == 30'd0));
endmodule

bind bank_window_top bank_window_chk #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_WORDS(WIN_WORDS), .NUM_CFG(NUM_CFG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .we        (we),
    .addr      (addr),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .pkt_sent  (pkt_sent),
    .bank_q    (bank_q),
    .pkt_count (pkt_count),
    .cfg_out   (cfg_out)
);

// File: tb/tb_bank_window_top.sv
module tb_bank_window_top;
    localparam int          ADDR_W     = 6;
    localparam int          NUM_STATUS = 2;
    localparam int          NUM_CFG    = 4;
    localparam logic [63:0] CNT_RST    = 64'hFFFF_FFFF_FFFF_FFF8;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     req = 1'b0, we = 1'b0, pkt_sent = 1'b0;
    logic [ADDR_W-1:0]        addr = '0;
    logic [31:0]              wr_data = '0;
    logic [31:0]              rd_data;
    logic                     rd_valid;
    logic [32*NUM_STATUS-1:0] status_in = {32'h5A5A_0002, 32'hA5A5_0001};
    logic [32*NUM_CFG-1:0]    cfg_out;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [63:0] exp_cnt = CNT_RST;
    logic [31:0] cfg_model [NUM_CFG];

    always #2.5 clk = ~clk;

    bank_window_top #(
        .ADDR_W(ADDR_W), .NUM_STATUS(NUM_STATUS), .NUM_CFG(NUM_CFG), .CNT_RESET(CNT_RST)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
        .pkt_sent(pkt_sent), .status_in(status_in), .cfg_out(cfg_out)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", r, act, exp);
        end
    endtask

    // one bus cycle starting at a falling edge; result read at the next falling edge
    task automatic bus(input logic w, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                       input logic p, output logic [31:0] q);
        req = 1'b1; we = w; addr = a; wr_data = d; pkt_sent = p;
        @(posedge clk);
        @(negedge clk);
        if (p) exp_cnt = exp_cnt + 64'd1;
        req = 1'b0; we = 1'b0; pkt_sent = 1'b0;
        q = rd_data;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        logic [31:0] q;
        bus(1'b1, a, d, 1'b0, q);
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] q);
        bus(1'b0, a, 32'd0, 1'b0, q);
    endtask

    function automatic logic [31:0] exp_word(input int b, input int o);
        case (b)
            0: return (o < NUM_STATUS) ? status_in[o*32 +: 32] : 32'd0;
            1: return (o < NUM_CFG) ? cfg_model[o] : 32'd0;
            2: return (o == 0) ? exp_cnt[31:0] : (o == 1) ? exp_cnt[63:32] : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] q;
        for (int i = 0; i < NUM_CFG; i++) cfg_model[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
        chk("R1 rd_data", rd_data, 32'd0);
        chk("R1 cfg_out", cfg_out[31:0] | cfg_out[127:96], 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(6'd0, q); chk("R1 bank code", q, 32'd0);

        // R10 rd_valid timing
        req = 1'b1; we = 1'b0; addr = 6'h10;
        @(posedge clk); @(negedge clk);
        req = 1'b0;
        chk("R10 rd_valid high", {31'd0, rd_valid}, 32'd1);
        @(negedge clk);
        chk("R10 rd_valid low", {31'd0, rd_valid}, 32'd0);

        // R5 fill configuration bank via window, all offsets
        wr(6'd0, 32'd1);
        for (int o = 0; o < 16; o++) begin
            wr(6'(16 + o), 32'hC0F0_0000 + 32'(o) * 32'h111);
            if (o < NUM_CFG) cfg_model[o] = 32'hC0F0_0000 + 32'(o) * 32'h111;
        end
        for (int i = 0; i < NUM_CFG; i++)
            chk("R5 cfg_out word", cfg_out[i*32 +: 32], cfg_model[i]);

        // R4 R6 R9 writes into non-config banks are discarded
        for (int b = 0; b < 4; b++) begin
            if (b == 1) continue;
            wr(6'd0, 32'(b));
            for (int o = 0; o < 16; o++) wr(6'(16 + o), 32'hDEAD_0000 + 32'(o));
        end
        for (int i = 0; i < NUM_CFG; i++)
            chk("R9 cfg unchanged by other-bank writes", cfg_out[i*32 +: 32], cfg_model[i]);

        // R10 writes outside select and window ignored
        wr(6'd0, 32'd1);
        wr(6'd5, 32'h1234_5678);
        wr(6'h20, 32'h1234_5678);
        rd(6'd0, q); chk("R10 select untouched by stray writes", q, 32'd1);
        for (int i = 0; i < NUM_CFG; i++)
            chk("R10 cfg untouched by stray writes", cfg_out[i*32 +: 32], cfg_model[i]);
        for (int a = 1; a < 64; a++) begin
            if (a >= 16 && a < 32) continue;
            rd(6'(a), q); chk("R10 unmapped read zero", q, 32'd0);
        end

        // R2 R3 R4 R5 R6 R9 sweep: select then window access on the next cycle
        for (int b = 0; b < 4; b++) begin
            wr(6'd0, {30'h3FFF_FFFF, 2'(b)});
            rd(6'd0, q); chk("R2 bank code readback", q, 32'(b));
            for (int o = 0; o < 16; o++) begin
                wr(6'd0, 32'(b));
                rd(6'(16 + o), q);
                chk(b == 0 ? "R3 R4 status window" : b == 1 ? "R3 R5 config window" :
                    b == 2 ? "R3 R6 stats window" : "R3 R9 empty bank",
                    q, exp_word(b, o));
            end
        end

        // R7 R8 coherent split read across the wrap
        wr(6'd0, 32'd2);
        rd(6'h10, q); chk("R6 low half", q, 32'hFFFF_FFF8);
        for (int i = 0; i < 3; i++) bus(1'b0, 6'h00, 32'd0, 1'b1, q);
        rd(6'h11, q); chk("R7 high from shadow", q, 32'hFFFF_FFFF);
        for (int i = 0; i < 4; i++) bus(1'b0, 6'h00, 32'd0, 1'b1, q);
        bus(1'b0, 6'h10, 32'd0, 1'b1, q);
        chk("R8 low read with pulse returns pre-increment", q, 32'hFFFF_FFFF);
        rd(6'h11, q); chk("R7 shadow keeps pre-wrap high", q, 32'hFFFF_FFFF);
        rd(6'h11, q); chk("R7 idle high read is live, R8 wrapped", q, 32'd0);
        rd(6'h10, q); chk("R8 low after wrap", q, 32'd0);
        rd(6'h11, q); chk("R8 high after wrap", q, exp_cnt[63:32]);
        for (int i = 0; i < 5; i++) bus(1'b0, 6'h00, 32'd0, 1'b1, q);
        wr(6'h10, 32'hFFFF_FFFF);
        rd(6'h10, q); chk("R6 R8 count after pulses, writes ignored", q, exp_cnt[31:0]);
        chk("R8 model", q, 32'd5);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule